// File: doc/BRIEF.md
# Configuration Start-Up Sequencer

This block orders the three events that end device configuration: letting go of the shared open-drain completion pin, taking the flip-flops out of global set/reset, and turning on the user I/O drivers. It waits until a length counter has seen the programmed number of configuration-clock edges since the initialisation signal went high, and until the end-of-configuration frame has been marked as written. After that it times each event from rising edges of a chosen clock.

Both clocks reach the block as one-cycle tick strobes on the sequencer clock `clk`. One mode input selects which tick paces the events: the configuration tick or the user tick. A second mode input selects either free-running timing, where all three events count ticks from start-up, or synchronized timing. In synchronized timing the flip-flop release and the I/O enable count from the observed rise of the wired-AND completion pin, after a two-flop synchronizer. Any device that holds that pin low therefore stalls them. Each event has its own 3-bit delay field, so the three events can happen in any order or together.

Top module: `startup_sequencer`

## Requirements
- R1: After reset, `done_release` is 0, `gsr_active` is 1 and `io_enable` is 0.
- R2: No event occurs before start-up begins. Start-up needs both of these: (a) the count of `cfg_tick` pulses seen while `init_high` is 1 equals `length_cnt`, and (b) `eoc_written` has been seen high. Ticks while `init_high` is 0 are not counted.
- R3: `done_release` rises on the selected tick numbered `done_dly`+1 after start-up, so the default delay of 0 releases it on the first tick.
- R4: With `use_user_clk`=1 only `usr_tick` paces the events. With 0 only `cfg_tick` does. The length count always uses `cfg_tick`.
- R5: With `sync_mode`=0, flip-flop release (`gsr_active` falls) happens on selected tick `gsr_dly`+1 after start-up, and `io_enable` rises on tick `io_dly`+1, whatever the level of `done_pin`.
- R6: With `sync_mode`=1, each of the other two events happens k selected ticks after the synchronized `done_pin` is seen high while `done_release` is 1. Here k is its delay field, with values 5 to 7 treated as 4. A field of 0 means as soon as the pin is seen high.
- R7: With `sync_mode`=1, while `done_pin` stays low, `gsr_active` stays 1 and `io_enable` stays 0, for any number of ticks.
- R8: Once asserted, each of the three event outputs keeps its released value until reset.
- R9: Reset returns the block to idle and clears the length count, so a new start-up again needs the full `length_cnt` ticks.
- R10: Events whose settings give the same tick fire on the same tick. Any order among the three is reachable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Synchronous active-high configuration reset |
| init_high | input | 1 | Initialisation signal has gone high; enables length counting |
| eoc_written | input | 1 | End-of-configuration frame written |
| length_cnt | input | LEN_W | Programmed length count |
| cfg_tick | input | 1 | One-cycle strobe per configuration-clock rising edge |
| usr_tick | input | 1 | One-cycle strobe per user-clock rising edge |
| use_user_clk | input | 1 | 1: events paced by `usr_tick`, 0: by `cfg_tick` |
| sync_mode | input | 1 | 1: synchronized to completion pin, 0: free-running |
| done_dly | input | 3 | Delay field of the completion-pin release |
| gsr_dly | input | 3 | Delay field of the flip-flop set/reset release |
| io_dly | input | 3 | Delay field of the I/O enable |
| done_pin | input | 1 | Sampled level of the wired-AND completion pin |
| done_release | output | 1 | 1: stop driving the completion pin low |
| gsr_active | output | 1 | 1: global set/reset held on internal flip-flops |
| io_enable | output | 1 | 1: user I/O drivers enabled |

## Verification
Each start-up is driven with the mode pair and the three delay fields, and every output is compared after each selected tick against the tick number the requirements predict. Free-running runs with the completion pin held low show that this mode ignores the pin. In synchronized runs the pin is freed early, freed late or never freed, which separates counting from the pin rise from counting from start-up and exposes the clamp at four. In user-clock runs, configuration ticks are inserted between user ticks and must change nothing. Runs where end-of-configuration arrives late, a reset in the middle of a run, and random settings from a fixed seed cover the start gate and the clearing of the length count.

// File: rtl/su_pkg.sv
package su_pkg;
    localparam int DLY_W    = 3;
    localparam int CNT_W    = DLY_W + 1;
    localparam int SYNC_MAX = 4;
    localparam int N_SLOTS  = 2;

    typedef struct packed {
        logic use_user_clk;
        logic sync_mode;
    } su_mode_t;

    // Delay after the observed pin rise, clamped to the synchronized maximum
    function automatic logic [CNT_W-1:0] sync_wait(input logic [DLY_W-1:0] d);
        if (int'(d) > SYNC_MAX) return CNT_W'(SYNC_MAX);
        return {1'b0, d};
    endfunction

    // Tick number on which a free-running event fires
    function automatic logic [CNT_W-1:0] free_tick(input logic [DLY_W-1:0] d);
        return {1'b0, d} + CNT_W'(1);
    endfunction
endpackage

// File: rtl/su_len_counter.sv
module su_len_counter #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             init_high,
    input  logic             cfg_tick,
    input  logic             eoc_written,
    input  logic [LEN_W-1:0] length_cnt,
    output logic             started
);
    logic [LEN_W-1:0] cnt_q;
    logic             eoc_q;
    logic             reached;

    assign reached = (cnt_q == length_cnt);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            eoc_q   <= 1'b0;
            started <= 1'b0;
        end else begin
            if (eoc_written) eoc_q <= 1'b1;
            if (init_high && cfg_tick && !reached && !started)
                cnt_q <= cnt_q + LEN_W'(1);
            if (!started && init_high && reached && eoc_q)
                started <= 1'b1;
        end
    end

    // R2: start-up only follows a full length count and a written end frame
    assert_start_gate_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(started) |-> $past(eoc_q) && $past(cnt_q == length_cnt));
endmodule

// File: rtl/su_pin_sync.sv
module su_pin_sync (
    input  logic clk,
    input  logic rst,
    input  logic pin_raw,
    output logic pin_sync
);
    logic s1_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q     <= 1'b0;
            pin_sync <= 1'b0;
        end else begin
            s1_q     <= pin_raw;
            pin_sync <= s1_q;
        end
    end
endmodule

// File: rtl/su_edge_counter.sv
module su_edge_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         tick,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] SAT = '1;

    always_ff @(posedge clk) begin
        if (rst)                          cnt <= '0;
        else if (en && tick && cnt != SAT) cnt <= cnt + W'(1);
    end

    // R3: the tick count saturates instead of wrapping back to zero
    assert_no_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0) |=> (cnt != '0));
endmodule

// File: rtl/su_event_slot.sv
module su_event_slot
    import su_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sync_mode,
    input  logic             pin_seen,
    input  logic [CNT_W-1:0] start_cnt,
    input  logic [CNT_W-1:0] post_cnt,
    input  logic [DLY_W-1:0] dly,
    output logic             released
);
    logic fire;

    always_comb begin
        if (sync_mode) fire = pin_seen && (post_cnt >= sync_wait(dly));
        else           fire = (start_cnt >= free_tick(dly));
    end

    always_ff @(posedge clk) begin
        if (rst)       released <= 1'b0;
        else if (fire) released <= 1'b1;
    end

    // R7: a pin that was never seen high holds the event back
    assert_hold_block_R7: assert property (@(posedge clk) disable iff (rst)
        (sync_mode && !pin_seen && !released) |=> !released);
endmodule

// File: rtl/startup_sequencer.sv
module startup_sequencer
    import su_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             init_high,
    input  logic             eoc_written,
    input  logic [LEN_W-1:0] length_cnt,
    input  logic             cfg_tick,
    input  logic             usr_tick,
    input  logic             use_user_clk,
    input  logic             sync_mode,
    input  logic [2:0]       done_dly,
    input  logic [2:0]       gsr_dly,
    input  logic [2:0]       io_dly,
    input  logic             done_pin,
    output logic             done_release,
    output logic             gsr_active,
    output logic             io_enable
);
    su_mode_t                       mode;
    logic                           started;
    logic                           sel_tick;
    logic                           pin_sync;
    logic                           pin_seen;
    logic [CNT_W-1:0]               start_cnt;
    logic [CNT_W-1:0]               post_cnt;
    logic [N_SLOTS-1:0][DLY_W-1:0]  slot_dly;
    logic [N_SLOTS-1:0]             slot_rel;

    assign mode.use_user_clk = use_user_clk;
    assign mode.sync_mode    = sync_mode;
    assign sel_tick          = mode.use_user_clk ? usr_tick : cfg_tick;

    su_len_counter #(.LEN_W(LEN_W)) len_i (
        .clk        (clk),
        .rst        (rst),
        .init_high  (init_high),
        .cfg_tick   (cfg_tick),
        .eoc_written(eoc_written),
        .length_cnt (length_cnt),
        .started    (started)
    );

    su_pin_sync pin_i (
        .clk     (clk),
        .rst     (rst),
        .pin_raw (done_pin),
        .pin_sync(pin_sync)
    );

    su_edge_counter #(.W(CNT_W)) start_cnt_i (
        .clk (clk),
        .rst (rst),
        .en  (started),
        .tick(sel_tick),
        .cnt (start_cnt)
    );

    su_edge_counter #(.W(CNT_W)) post_cnt_i (
        .clk (clk),
        .rst (rst),
        .en  (pin_seen),
        .tick(sel_tick),
        .cnt (post_cnt)
    );

    // Completion-pin release always counts from start-up
    always_ff @(posedge clk) begin
        if (rst) begin
            done_release <= 1'b0;
            pin_seen     <= 1'b0;
        end else begin
            if (start_cnt >= free_tick(done_dly)) done_release <= 1'b1;
            if (started && done_release && pin_sync) pin_seen <= 1'b1;
        end
    end

    assign slot_dly[0] = gsr_dly;
    assign slot_dly[1] = io_dly;

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
        su_event_slot slot_i (
            .clk      (clk),
            .rst      (rst),
            .sync_mode(mode.sync_mode),
            .pin_seen (pin_seen),
            .start_cnt(start_cnt),
            .post_cnt (post_cnt),
            .dly      (slot_dly[g]),
            .released (slot_rel[g])
        );
    end

    assign gsr_active = !slot_rel[0];
    assign io_enable  = slot_rel[1];

    // R2: all outputs idle until start-up begins
    assert_idle_until_start_R2: assert property (@(posedge clk) disable iff (rst)
        !started |-> (!done_release && gsr_active && !io_enable));

    // R6: in synchronized mode the other events never precede the pin release
    assert_sync_after_done_R6: assert property (@(posedge clk) disable iff (rst)
        (sync_mode && (!gsr_active || io_enable)) |-> done_release);

    // R8: released outputs stay released
    assert_sticky_done_R8: assert property (@(posedge clk) disable iff (rst)
        done_release |=> done_release);
    assert_sticky_gsr_R8: assert property (@(posedge clk) disable iff (rst)
        !gsr_active |=> !gsr_active);
    assert_sticky_io_R8: assert property (@(posedge clk) disable iff (rst)
        io_enable |=> io_enable);
endmodule

// File: tb/startup_sequencer_tb_top.sv
module startup_sequencer_tb_top;
    localparam int LEN_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             init_high = 1'b0;
    logic             eoc_written = 1'b0;
    logic [LEN_W-1:0] length_cnt = '0;
    logic             cfg_tick = 1'b0;
    logic             usr_tick = 1'b0;
    logic             use_user_clk = 1'b0;
    logic             sync_mode = 1'b1;
    logic [2:0]       done_dly = '0;
    logic [2:0]       gsr_dly = '0;
    logic [2:0]       io_dly = '0;
    logic             ext_hold = 1'b0;
    logic             done_pin;
    logic             done_release, gsr_active, io_enable;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    // wired-AND pin: low while this device drives it or another holds it
    assign done_pin = done_release & ~ext_hold;

    startup_sequencer #(.LEN_W(LEN_W)) dut_i (
        .clk(clk), .rst(rst), .init_high(init_high), .eoc_written(eoc_written),
        .length_cnt(length_cnt), .cfg_tick(cfg_tick), .usr_tick(usr_tick),
        .use_user_clk(use_user_clk), .sync_mode(sync_mode),
        .done_dly(done_dly), .gsr_dly(gsr_dly), .io_dly(io_dly),
        .done_pin(done_pin), .done_release(done_release),
        .gsr_active(gsr_active), .io_enable(io_enable)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit exp_free(input int n, input int d);
        return n >= d + 1;
    endfunction

    function automatic bit exp_sync(input int n, input int pin_idx, input int d);
        int k;
        k = (d > 4) ? 4 : d;
        if (pin_idx < 0) return 1'b0;
        return n >= pin_idx + k;
    endfunction

    task automatic step(input bit c, input bit u);
        @(negedge clk);
        cfg_tick = c;
        usr_tick = u;
        @(negedge clk);
        cfg_tick = 1'b0;
        usr_tick = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic check_all(input int n, input int pin_idx, input string note);
        bit eg, ei;
        string tg;
        if (sync_mode) begin
            eg = exp_sync(n, pin_idx, int'(gsr_dly));
            ei = exp_sync(n, pin_idx, int'(io_dly));
            tg = (pin_idx < 0) ? "R7" : "R6";
        end else begin
            eg = exp_free(n, int'(gsr_dly));
            ei = exp_free(n, int'(io_dly));
            tg = "R5/R10";
        end
        chk(done_release, exp_free(n, int'(done_dly)), {"R3 done ", note});
        chk(gsr_active, !eg, {tg, " gsr ", note});
        chk(io_enable, ei, {tg, " io ", note});
    endtask

    // hold_rel: 0 = pin never held, -1 = held forever, k = freed after step k
    task automatic run_scn(input bit usr, input bit syn, input int dd, input int dg,
                           input int di, input int len, input int hold_rel,
                           input bit eoc_late, input bit interleave, input int nsteps);
        int pin_idx;
        bit freed;
        rst = 1'b1; init_high = 1'b0; eoc_written = 1'b0;
        use_user_clk = usr; sync_mode = syn;
        done_dly = 3'(dd); gsr_dly = 3'(dg); io_dly = 3'(di);
        length_cnt = LEN_W'(len);
        ext_hold = (hold_rel != 0);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(done_release, 1'b0, "R1 done reset");
        chk(gsr_active, 1'b1, "R1 gsr reset");
        chk(io_enable, 1'b0, "R1 io reset");
        step(1'b1, 1'b0);                     // not counted: init low
        init_high = 1'b1;
        for (int i = 0; i < len - 1; i++) step(1'b1, 1'b0);
        if (!eoc_late) eoc_written = 1'b1;
        step(usr, 1'b1);
        chk(done_release, 1'b0, "R2 short length count");
        if (len > 0) step(1'b1, 1'b0);
        if (eoc_late) begin
            step(!usr, usr);
            step(!usr, usr);
            chk(done_release, 1'b0, "R2 no end frame");
            chk(gsr_active, 1'b1, "R2 no end frame");
            eoc_written = 1'b1;
        end
        repeat (4) @(negedge clk);
        pin_idx = -1;
        freed = (hold_rel == 0);
        for (int n = 1; n <= nsteps; n++) begin
            if (usr && interleave) begin
                step(1'b1, 1'b0);
                check_all(n - 1, pin_idx, "R4 cfg tick ignored");
            end
            if (usr) step(1'b0, 1'b1);
            else     step(1'b1, 1'b0);
            if (pin_idx < 0 && freed && n >= dd + 1) pin_idx = n;
            check_all(n, pin_idx, "step");
            if (n == hold_rel) begin
                ext_hold = 1'b0;
                freed = 1'b1;
                repeat (8) @(negedge clk);
                if (pin_idx < 0 && n >= dd + 1) pin_idx = n;
                check_all(n, pin_idx, "pin freed");
            end
        end
    endtask

    initial begin
        int seed;
        seed = $urandom(32'h5eed);
        // directed corners
        run_scn(0, 1, 0, 0, 0, 4, 0, 1, 0, 4);   // default mode, all immediate
        run_scn(0, 0, 2, 0, 5, 3, -1, 0, 0, 9);  // free-running, pin held, gsr first
        run_scn(1, 1, 1, 3, 6, 2, 4, 0, 1, 10);  // user clock, late pin, clamp
        run_scn(0, 1, 0, 1, 2, 1, -1, 0, 0, 12); // pin held forever
        run_scn(1, 0, 3, 3, 3, 5, 0, 1, 1, 6);   // simultaneous events
        run_scn(0, 1, 2, 7, 0, 0, 1, 0, 0, 9);   // zero length, pin freed early
        // random settings
        for (int r = 0; r < 8; r++) begin
            int hr;
            hr = int'($urandom_range(0, 2));
            if (hr == 2) hr = int'($urandom_range(1, 8));
            else if (hr == 1) hr = -1;
            run_scn(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                    int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
                    int'($urandom_range(0, 7)), int'($urandom_range(1, 6)),
                    hr, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 12);
        end
        // R9: reset mid-run clears the length count
        run_scn(0, 0, 0, 0, 0, 3, 0, 0, 0, 2);
        chk(io_enable, 1'b1, "R8 io still enabled");
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(done_release, 1'b0, "R9 done after reset");
        chk(gsr_active, 1'b1, "R9 gsr after reset");
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        chk(done_release, 1'b0, "R9 count restarted");
        step(1'b1, 1'b0);   // third tick completes the count
        repeat (3) @(negedge clk);
        step(1'b1, 1'b0);
        chk(done_release, 1'b1, "R9 release after full count");
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule